// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Memory

This block is a single-ported synchronous word memory with a four-beat burst address generator, intended to sit on a processor or cache-controller bus. A cycle opens a burst when either of two address strobes is high at a rising clock edge. That edge captures the address, the chip-select state and the burst order. Following beats are addressed internally. Their low two address bits come from a 2-bit counter that steps only when the advance input is high. A burst follows either linear order (the low bits count up modulo 4) or interleaved order (the low bits are the start bits XOR the count).

The read path is flow-through. The word at the address in effect after an edge appears on the read port during that same cycle, with no output register, so a four-beat burst runs at 2-1-1-1. Writes take effect at the clock edge. They are masked per byte lane, and a global write forces all lanes. The output enable gates the read port combinationally. The write and read data ports are separate.

Top module: `fts_burst_ram`

## Requirements
- R1: When `ads_cpu` or `ads_ctl` is high at a rising edge, `addr`, the chip selects and `burst_ilv` are captured, and the captured address is the address in effect in the cycle that follows. At edges without a strobe, `addr`, the chip selects and `burst_ilv` are ignored.
- R2: With `burst_ilv` low at the strobe, the low two address bits follow the order s, s+1, s+2, s+3 modulo 4, where s is the start value. The upper bits do not change.
- R3: With `burst_ilv` high at the strobe, the low two address bits follow s XOR 0, s XOR 1, s XOR 2, s XOR 3.
- R4: The burst count steps only at edges where `adv` is high and there is no strobe. Otherwise the address is held. After the fourth beat the count wraps to the start address.
- R5: A strobe during a burst aborts that burst and restarts the count from the new address.
- R6: When `all_we` is high at an edge in a selected cycle, every byte lane of the current word is written from `wdata`, whatever the values of `lane_we` and `byte_we_en`.
- R7: When `all_we` is low and `byte_we_en` is high, only the lanes i with `lane_we[i]` high are written, where lane i is bits [9i+8:9i]. When both are low, the cycle is a read and the memory is not changed.
- R8: The device is selected only when `cs_a` is high, `cs_b` is high and `cs_c_n` is low at the strobe. While the device is deselected, `rdata` is zero and no write takes place until the next strobe that selects it.
- R9: In a selected read cycle with `oe` high, `rdata` shows the word stored at the address in effect after the edge, during that same cycle.
- R10: `rdata` is zero whenever `oe` is low, and this follows `oe` without waiting for a clock edge. `rdata` is also zero during write cycles.
- R11: After reset the device is deselected and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured at a strobe |
| ads_cpu | input | 1 | Processor address strobe, active high |
| ads_ctl | input | 1 | Controller address strobe, active high |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | Burst advance |
| burst_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| lane_we | input | LANES | Per-lane write enables |
| byte_we_en | input | 1 | Enables the per-lane write enables |
| all_we | input | 1 | Writes all lanes |
| oe | input | 1 | Asynchronous output enable |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data |

## Verification
Two things can happen at the same edge: a burst advance, or a fresh strobe that aborts the burst. A write can also fall at the same edge as either one. The bench provokes both cases. It writes a whole burst with `adv` high on every beat. It also raises `ads_ctl` in the middle of a read burst while `adv` is still high, so the strobe must win and the read must come from the new address. A reference model built from the requirements predicts the address and the data of every cycle, and the scoreboard compares `rdata` after each edge. Writes issued while the device is deselected are judged later, when the untouched words are read back.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // Low two bits of a burst beat from the start bits and the beat count.
   function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
      logic [1:0] r;
      if (ilv) r = start ^ beat;
      else     r = 2'(start + beat);
      return r;
   endfunction

endpackage

// File: rtl/fts_addr_ctl.sv
module fts_addr_ctl
   import fts_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe,
   input  logic              sel_in,
   input  logic              adv,
   input  logic              ilv_in,
   output logic              nxt_sel,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              sel_q,
   output logic              ilv_q,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int HI_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q, nxt_base;
   logic [1:0]        cnt_q, nxt_cnt;
   logic              nxt_ilv;

   always_comb begin
      if (strobe) begin
         nxt_sel  = sel_in;
         nxt_base = addr;
         nxt_ilv  = ilv_in;
         nxt_cnt  = 2'd0;
      end else begin
         nxt_sel  = sel_q;
         nxt_base = base_q;
         nxt_ilv  = ilv_q;
         nxt_cnt  = (sel_q && adv) ? 2'(cnt_q + 2'd1) : cnt_q;
      end
   end

   assign nxt_addr = {nxt_base[ADDR_W-1 -: HI_W], burst_lsb(nxt_base[1:0], nxt_cnt, nxt_ilv)};
   assign cur_addr = {base_q[ADDR_W-1 -: HI_W], burst_lsb(base_q[1:0], cnt_q, ilv_q)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         ilv_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else begin
         sel_q  <= nxt_sel;
         ilv_q  <= nxt_ilv;
         base_q <= nxt_base;
         cnt_q  <= nxt_cnt;
      end
   end
endmodule

// File: rtl/fts_lane_store.sv
module fts_lane_store #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANE_W-1:0] wdat,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LANE_W-1:0] rdat
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdat;
   end

   assign rdat = mem[raddr];
endmodule

// File: rtl/fts_out_gate.sv
module fts_out_gate #(
   parameter int DATA_W = 36
)(
   input  logic              oe,
   input  logic              sel_q,
   input  logic              wr_q,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);
   logic drive;
   assign drive = oe && sel_q && !wr_q;
   assign rdata = drive ? word : '0;
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
   parameter  int ADDR_W = 8,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 9,
   localparam int DATA_W = LANES * LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ads_cpu,
   input  logic              ads_ctl,
   input  logic              cs_a,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              adv,
   input  logic              burst_ilv,
   input  logic [LANES-1:0]  lane_we,
   input  logic              byte_we_en,
   input  logic              all_we,
   input  logic              oe,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
         $error("fts_burst_ram: ADDR_W must lie in 3..12");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("fts_burst_ram: LANES and LANE_W must be positive");
      end
   endgenerate

   logic              strobe, sel_in;
   logic              nxt_sel, sel_q, ilv_q, wr_q;
   logic [ADDR_W-1:0] nxt_addr, cur_addr;
   logic [LANES-1:0]  lane_wr;
   logic [DATA_W-1:0] word;

   assign strobe = ads_cpu | ads_ctl;
   assign sel_in = cs_a & cs_b & ~cs_c_n;

   fts_addr_ctl #(.ADDR_W(ADDR_W)) u_actl (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .strobe   (strobe),
      .sel_in   (sel_in),
      .adv      (adv),
      .ilv_in   (burst_ilv),
      .nxt_sel  (nxt_sel),
      .nxt_addr (nxt_addr),
      .sel_q    (sel_q),
      .ilv_q    (ilv_q),
      .cur_addr (cur_addr)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_wr[i] = nxt_sel && (all_we || (byte_we_en && lane_we[i]));

      fts_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
         .clk   (clk),
         .we    (lane_wr[i]),
         .waddr (nxt_addr),
         .wdat  (wdata[i*LANE_W +: LANE_W]),
         .raddr (cur_addr),
         .rdat  (word[i*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= |lane_wr;
   end

   fts_out_gate #(.DATA_W(DATA_W)) u_out (
      .oe    (oe),
      .sel_q (sel_q),
      .wr_q  (wr_q),
      .word  (word),
      .rdata (rdata)
   );
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 36
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ads_cpu,
   input logic              ads_ctl,
   input logic              cs_a,
   input logic              cs_b,
   input logic              cs_c_n,
   input logic              adv,
   input logic              oe,
   input logic [DATA_W-1:0] rdata,
   input logic              sel_q,
   input logic              ilv_q,
   input logic [ADDR_W-1:0] cur_addr
);
   logic strb;
   assign strb = ads_cpu | ads_ctl;

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      strb |=> cur_addr == $past(addr));

   p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && adv && sel_q && !ilv_q) |=> cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && !adv) |=> $stable(cur_addr));

   p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !(cs_a && cs_b && !cs_c_n)) |=> rdata == '0);

   p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> rdata == '0);

   p_reset_desel_r11: assert property (@(posedge clk)
      !rst_n |=> !sel_q);
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .ads_cpu  (ads_cpu),
   .ads_ctl  (ads_ctl),
   .cs_a     (cs_a),
   .cs_b     (cs_b),
   .cs_c_n   (cs_c_n),
   .adv      (adv),
   .oe       (oe),
   .rdata    (rdata),
   .sel_q    (sel_q),
   .ilv_q    (ilv_q),
   .cur_addr (cur_addr)
);

// File: tb/fts_burst_ram_tb.sv
module fts_burst_ram_tb;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ads_cpu = 1'b0, ads_ctl = 1'b0;
   logic          cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1;
   logic          adv = 1'b0, burst_ilv = 1'b0;
   logic [NL-1:0] lane_we = '0;
   logic          byte_we_en = 1'b0, all_we = 1'b0, oe = 1'b1;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   always #5 clk = ~clk;

   fts_burst_ram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ads_cpu(ads_cpu), .ads_ctl(ads_ctl),
      .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n), .adv(adv), .burst_ilv(burst_ilv),
      .lane_we(lane_we), .byte_we_en(byte_we_en), .all_we(all_we), .oe(oe),
      .wdata(wdata), .rdata(rdata)
   );

   typedef struct { logic [DW-1:0] exp; string tag; } item_t;
   item_t sb[$];

   int total = 0, bad = 0;
   bit done = 1'b0;

   // reference model state
   logic [DW-1:0] ref_mem [1<<AW];
   logic          m_sel = 1'b0, m_ilv = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = 2'd0;

   function automatic logic [DW-1:0] pat(input logic [7:0] a, input logic b);
      return {4{b, a}};
   endfunction

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic cpu, input logic ctl, input logic [AW-1:0] a,
                       input logic sel, input logic ad, input logic ilv,
                       input logic [NL-1:0] lw, input logic bwe, input logic gw,
                       input logic o, input logic [DW-1:0] wd, input string tag);
      logic [1:0]    lo;
      logic [AW-1:0] na;
      logic          wr;
      item_t         it;
      @(negedge clk);
      ads_cpu = cpu; ads_ctl = ctl; addr = a;
      cs_a = sel; cs_b = sel; cs_c_n = ~sel;
      adv = ad; burst_ilv = ilv; lane_we = lw; byte_we_en = bwe; all_we = gw;
      oe = o; wdata = wd;
      if (cpu || ctl) begin
         m_sel = sel; m_base = a; m_cnt = 2'd0; m_ilv = ilv;
      end else if (m_sel && ad) begin
         m_cnt = 2'(m_cnt + 2'd1);
      end
      lo = m_ilv ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
      na = {m_base[AW-1:2], lo};
      wr = 1'b0;
      if (m_sel) begin
         for (int i = 0; i < NL; i++) begin
            if (gw || (bwe && lw[i])) begin
               ref_mem[na][i*LW +: LW] = wd[i*LW +: LW];
               wr = 1'b1;
            end
         end
      end
      it.exp = (o && m_sel && !wr) ? ref_mem[na] : '0;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare after every edge, away from it
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(rdata, it.exp, it.tag);
      end
   end

   task automatic rd(input logic cpu, input logic ctl, input logic [AW-1:0] a,
                     input logic ad, input logic ilv, input string tag);
      step(cpu, ctl, a, 1'b1, ad, ilv, '0, 1'b0, 1'b0, 1'b1, '0, tag);
   endtask

   initial begin
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      #1 check(rdata, '0, "R11 reset output");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk) #2 check(rdata, '0, "R11 idle after reset");

      // R6 + R2: global write burst 0x10..0x13, advance on every beat
      step(1,0,8'h10,1,0,0,4'h0,0,1,1,pat(8'h10,0),"R6 write beat0");
      for (int k = 1; k < 4; k++)
         step(0,0,8'h00,1,1,0,4'h0,0,1,1,pat(8'(8'h10+k),0),"R6 write burst");
      // also fill 0x20..0x23 for later, via controller strobe (R1)
      step(0,1,8'h20,1,0,0,4'h0,0,1,1,pat(8'h20,0),"R1 ctl strobe write");
      for (int k = 1; k < 4; k++)
         step(0,0,8'h00,1,1,0,4'h0,0,1,1,pat(8'(8'h20+k),0),"R6 write burst2");

      // R2/R9/R4: linear read from 0x12, wraps after four beats
      rd(1,0,8'h12,0,0,"R9 linear beat0");
      rd(0,0,8'hFF,1,1,"R2 linear beat1 (addr/mode ignored, R1)");
      rd(0,0,8'h00,1,0,"R2 linear beat2");
      rd(0,0,8'h00,1,0,"R2 linear beat3");
      rd(0,0,8'h00,1,0,"R4 wrap to start");
      rd(0,0,8'h00,0,0,"R4 hold no adv");
      rd(0,0,8'h00,0,0,"R4 hold again");

      // R3: interleaved from 0x11 -> 11,10,13,12
      rd(0,1,8'h11,0,1,"R3 ilv beat0");
      rd(0,0,8'h00,1,1,"R3 ilv beat1");
      rd(0,0,8'h00,1,1,"R3 ilv beat2");
      rd(0,0,8'h00,1,1,"R3 ilv beat3");
      // R3 interleaved from 0x22 -> 22,23,20,21
      rd(1,0,8'h22,0,1,"R3 ilv2 beat0");
      rd(0,0,8'h00,1,1,"R3 ilv2 beat1");
      rd(0,0,8'h00,1,1,"R3 ilv2 beat2");

      // R5: abort with controller strobe while adv is high
      rd(1,0,8'h20,0,0,"R5 burst start");
      rd(0,0,8'h00,1,0,"R5 burst beat1");
      rd(0,1,8'h13,1,0,"R5 abort reload");
      rd(0,0,8'h00,1,0,"R5 after reload linear");

      // R7: masked byte write lanes 0 and 2 on 0x10
      step(1,0,8'h10,1,0,0,4'b0101,1,0,1,pat(8'hEE,1),"R7 byte write cycle");
      rd(0,0,8'h00,0,0,"R7 masked readback");
      // R7: enables off -> read cycle, no change
      step(0,0,8'h00,1,0,0,4'b1111,0,0,1,pat(8'h77,1),"R7 both off is read");
      rd(0,0,8'h00,0,0,"R7 word unchanged");
      // R6: global write overrides empty lane mask
      step(0,0,8'h00,1,1,0,4'b0000,0,1,1,pat(8'h5A,1),"R6 global write");
      rd(0,0,8'h00,0,0,"R6 global readback");

      // R8: deselected strobe, writes attempted
      step(1,0,8'h12,0,0,0,4'h0,0,1,1,pat(8'h99,1),"R8 deselect strobe");
      step(0,0,8'h00,0,1,0,4'hF,1,1,1,pat(8'h98,1),"R8 deselected adv write");
      step(0,0,8'h00,0,1,0,4'hF,1,0,1,pat(8'h97,1),"R8 deselected byte write");
      rd(1,0,8'h12,1,0,"R8 word 0x12 untouched");
      rd(0,0,8'h00,1,0,"R8 word 0x13 untouched");

      // R10: oe low gives zero
      step(0,0,8'h00,1,0,0,4'h0,0,0,0,'0,"R10 oe low");
      rd(0,0,8'h00,0,0,"R10 oe back high");
      @(posedge clk); #3;
      oe = 1'b0; #1 check(rdata, '0, "R10 async oe drop");
      oe = 1'b1; #1 check(rdata, ref_mem[8'h13], "R10 async oe rise");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule